// File: doc/BRIEF.md
# Frame-Done Interrupt With Clear-On-Read

This block holds one status bit per display channel. The bit is set when that channel has finished reading out its current frame buffer. The block raises one interrupt line whenever a set status bit has its channel enabled. The host reads the status bits with a single read strobe. A normal read returns the bits and then clears them. A read marked as coming from a debugger returns the same bits but clears nothing, so inspecting the block never loses an event.

The per-channel enables are double buffered. A host write updates a shadow copy only. Each channel copies its shadow bit into its active enable at that channel's next frame-done event, so an enable change always takes effect on a frame boundary. The interrupt line is a registered level and not a pulse.

Top module: `frame_done_irq`

## Requirements
- R1: After reset, all status bits, all active enables, all shadow enables and the interrupt output are 0.
- R2: A 1 on `frame_done[i]` in a cycle makes `status[i]` read as 1 from the next cycle on. The other channels are unaffected.
- R3: A read with `rd_stb`=1 and `rd_dbg`=0 shows the current status on `status` in that same cycle. All status bits then read as 0 from the next cycle, except bits set by R5.
- R4: A read with `rd_stb`=1 and `rd_dbg`=1 (master ID bit 0 marks a debugger) leaves every status bit unchanged.
- R5: If `frame_done[i]` and a clearing read fall in the same cycle, `status[i]` is 1 afterwards.
- R6: `en_wr`=1 loads `en_wdata` into the shadow enables only. `en_active[i]` changes only in the cycle after `frame_done[i]`=1, and it then takes shadow bit i.
- R7: If an enable write and `frame_done[i]` fall in the same cycle, `en_active[i]` takes the shadow value held before the write. The new value waits for the next event on that channel.
- R8: `irq` is a registered level. In each cycle it equals the OR over i of `status[i] & en_active[i]` from the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | N_DISP | Per-channel frame buffer consumed event |
| rd_stb | input | 1 | Status register read strobe |
| rd_dbg | input | 1 | Master ID bit 0 of the read; 1 marks a debugger |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | N_DISP | Enable write data |
| status | output | N_DISP | Current status bits, the read value |
| en_active | output | N_DISP | Active per-channel enables |
| irq | output | 1 | Interrupt level |

## Verification
A two-channel instance is driven with every combination of frame-done pattern, read kind (none, clearing, debugger), enable write and write data. The sweep is run twice, so that each combination meets different held states. This tells a clearing read apart from a debugger read, and it shows whether a frame-done event beats a clear in the same cycle. It also catches an enable that takes effect on the write instead of at the frame boundary, and a shadow that is sampled after the write of the same cycle. Directed steps before the sweep cover reset, and they show the one-cycle lag of the interrupt level behind the status and enable bits.

// File: rtl/frame_done_irq.sv
module frame_done_irq #(
  parameter int N_DISP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DISP-1:0] frame_done,
  input  logic              rd_stb,
  input  logic              rd_dbg,
  input  logic              en_wr,
  input  logic [N_DISP-1:0] en_wdata,
  output logic [N_DISP-1:0] status,
  output logic [N_DISP-1:0] en_active,
  output logic              irq
);

  logic [N_DISP-1:0] stat_q, shadow_q, act_q;
  logic              irq_q;
  logic              clr;

  assign clr = rd_stb & ~rd_dbg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q   <= '0;
      shadow_q <= '0;
      act_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      stat_q   <= frame_done | (clr ? '0 : stat_q);
      act_q    <= (frame_done & shadow_q) | (~frame_done & act_q);
      irq_q    <= |(stat_q & act_q);
      if (en_wr) shadow_q <= en_wdata;
    end
  end

  assign status    = stat_q;
  assign en_active = act_q;
  assign irq       = irq_q;

endmodule

// File: rtl/frame_done_irq_chk.sv
module frame_done_irq_chk #(
  parameter int N_DISP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_DISP-1:0] frame_done,
  input logic              rd_stb,
  input logic              rd_dbg,
  input logic [N_DISP-1:0] status,
  input logic [N_DISP-1:0] en_active,
  input logic              irq
);

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|frame_done) |=> ((status & $past(frame_done)) == $past(frame_done)));

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_dbg) |=> (status == $past(frame_done)));

  assert_debug_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_dbg && frame_done == '0) |=> $stable(status));

  assert_enable_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done == '0) |=> $stable(en_active));

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq == |($past(status) & $past(en_active))));

endmodule

bind frame_done_irq frame_done_irq_chk #(.N_DISP(N_DISP)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .rd_stb(rd_stb),
  .rd_dbg(rd_dbg), .status(status), .en_active(en_active), .irq(irq)
);

// File: tb/frame_done_irq_tb.sv
module frame_done_irq_tb_top;
  localparam int CLK_P = 10;
  localparam int N = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] frame_done = '0, en_wdata = '0;
  logic rd_stb = 0, rd_dbg = 0, en_wr = 0;
  logic [N-1:0] status, en_active;
  logic irq;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [N-1:0] m_st = '0, m_sh = '0, m_act = '0;
  logic m_irq = 0;

  always #(CLK_P/2) clk = ~clk;

  frame_done_irq #(.N_DISP(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .rd_stb(rd_stb),
    .rd_dbg(rd_dbg), .en_wr(en_wr), .en_wdata(en_wdata),
    .status(status), .en_active(en_active), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input int fd, input int rd, input int dbg,
                      input int we, input int wd);
    logic [N-1:0] fdv;
    fdv = fd[N-1:0];
    frame_done = fdv; rd_stb = rd[0]; rd_dbg = dbg[0];
    en_wr = we[0]; en_wdata = wd[N-1:0];
    #1;
    if (rd[0]) chk({tag, " R3 read value"}, int'(status), int'(m_st));
    @(posedge clk);
    m_irq = |(m_st & m_act);
    m_act = (fdv & m_sh) | (~fdv & m_act);
    m_st  = fdv | ((rd[0] && !dbg[0]) ? '0 : m_st);
    if (we[0]) m_sh = wd[N-1:0];
    @(negedge clk);
    chk({tag, " status"}, int'(status), int'(m_st));
    chk({tag, " en_active"}, int'(en_active), int'(m_act));
    chk({tag, " R8 irq"}, int'(irq), int'(m_irq));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", int'(status), 0);
    chk("R1 en_active", int'(en_active), 0);
    chk("R1 irq", int'(irq), 0);
    rst_n = 1;
    step("R1 shadow empty", 3, 0, 0, 0, 0);
    step("R2 set ch0", 1, 0, 0, 0, 0);
    step("R6 write shadow", 0, 0, 0, 1, 3);
    step("R6 no change yet", 0, 0, 0, 0, 0);
    step("R6 ch1 boundary", 2, 0, 0, 0, 0);
    step("R8 irq lag", 0, 0, 0, 0, 0);
    step("R4 debug read", 0, 1, 1, 0, 0);
    step("R3 clear read", 0, 1, 0, 0, 0);
    step("R5 set beats clear", 1, 1, 0, 0, 0);
    step("R7 write with event", 1, 0, 0, 1, 0);
    step("R7 new value later", 1, 0, 0, 0, 0);
    for (int r = 0; r < 2; r++)
      for (int fd = 0; fd < 4; fd++)
        for (int rk = 0; rk < 3; rk++)
          for (int we = 0; we < 2; we++)
            for (int wd = 0; wd < 4; wd++)
              step("sweep R2 R3 R4 R5 R6 R7", fd, rk != 0, rk == 2, we, wd);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule